// File: doc/BRIEF.md
# Switch Connection Memory Loader

This block owns the connection memory of a time-slot switching matrix. The memory has one entry for each output channel, addressed by output multiplex and output time slot. Each entry names the input multiplex and input time slot whose contents go to that output channel. A processor-side command port drives the block. Each command carries a destination multiplex and slot, a source multiplex and slot, a read bit, a transparent-connection bit and two range bits.

With the transparent-connection bit clear, a command reads or writes one entry. With the transparent-connection bit set on a write, the block makes identity connections, so that input slot i of multiplex j feeds output slot i of multiplex j. A single command can make one such connection, fill all 32 slots of one multiplex, or fill the whole 256-entry memory. The bulk fills write one entry per clock. While a fill runs, the block shows busy and refuses new commands.

Top module: `conn_mem_loader`

## Requirements
- R1: After reset, `busy` is 0, `cmd_ready` is 1 and `rd_valid` is 0.
- R2: An accepted command with `cmd_read`=0 and `cmd_tc`=0 stores `{cmd_src_mux, cmd_src_slot}` in the entry at address `{cmd_dst_mux, cmd_dst_slot}`. The multiplex field occupies bits 7:5 of the address and of the entry, and the slot field occupies bits 4:0.
- R3: An accepted command with `cmd_read`=1 returns the addressed entry on `rd_data`, with `rd_valid` high for exactly the one cycle after acceptance. This holds whatever the value of `cmd_tc`, and such a command changes no entry.
- R4: An accepted write with `cmd_tc`=1, `cmd_rng_hi`=0 and `cmd_rng_lo`=0 stores `{cmd_dst_mux, cmd_dst_slot}` in that same address and ignores the source fields. `busy` stays 0.
- R5: A transparent write with both range bits at 1 behaves exactly like the single-connection case of R4.
- R6: A transparent write with `cmd_rng_lo`=1 and `cmd_rng_hi`=0 writes the identity value into all 32 slots of the destination multiplex and leaves every other multiplex unchanged. `busy` is high for 32 cycles, starting the cycle after acceptance.
- R7: A transparent write with `cmd_rng_hi`=1 and `cmd_rng_lo`=0 writes the identity value into all 256 entries. `busy` is high for 256 cycles.
- R8: `cmd_ready` equals the inverse of `busy`. A command presented while `busy` is high is not taken and has no effect on the memory.
- R9: `rd_valid` is never high except in the cycle after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_dst_mux | input | 3 | Destination (output) multiplex |
| cmd_dst_slot | input | 5 | Destination (output) time slot |
| cmd_src_mux | input | 3 | Source (input) multiplex for normal writes |
| cmd_src_slot | input | 5 | Source (input) time slot for normal writes |
| cmd_read | input | 1 | 1 = read the addressed entry |
| cmd_tc | input | 1 | 1 = transparent connection on a write |
| cmd_rng_lo | input | 1 | Range select, low bit |
| cmd_rng_hi | input | 1 | Range select, high bit |
| busy | output | 1 | A bulk fill is in progress |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Entry read back: source multiplex in bits 7:5, source slot in bits 4:0 |

## Verification
The properties assume that command fields are meaningful only in a cycle where `cmd_valid` and `cmd_ready` are both high. They also assume that a fill is started only by a write with exactly one range bit set. The busy-length check counts cycles from the start of each fill, so it relies on fills never being chained without an idle cycle between them. The stimulus keeps every command held until it is accepted. It also drives a command during a fill on purpose, to show that the command is refused, and it drops `cmd_valid` before the fill ends.

// File: rtl/cml_pkg.sv
package cml_pkg;
    localparam int MUX_W  = 3;
    localparam int SLOT_W = 5;
    localparam int ADDR_W = MUX_W + SLOT_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] cm_addr_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_WRITE,
        OP_READ,
        OP_TC_ONE,
        OP_TC_MUX,
        OP_TC_ALL
    } cm_op_e;

    typedef struct packed {
        cm_op_e   op;
        cm_addr_t addr;
        cm_addr_t data;
    } cm_req_t;

    typedef struct packed {
        logic     busy;
        cm_addr_t ptr;
        cm_addr_t last;
    } fill_st_t;

    typedef struct packed {
        logic     valid;
        cm_addr_t data;
    } rd_st_t;
endpackage

// File: rtl/cml_decode.sv
module cml_decode
    import cml_pkg::*;
(
    input  logic              cmd_valid,
    input  logic              cmd_ready,
    input  logic [MUX_W-1:0]  dst_mux,
    input  logic [SLOT_W-1:0] dst_slot,
    input  logic [MUX_W-1:0]  src_mux,
    input  logic [SLOT_W-1:0] src_slot,
    input  logic              rd_bit,
    input  logic              tc_bit,
    input  logic              rng_lo,
    input  logic              rng_hi,
    output cm_req_t           req
);
    always_comb begin
        req.op   = OP_IDLE;
        req.addr = {dst_mux, dst_slot};
        req.data = {src_mux, src_slot};
        if (cmd_valid && cmd_ready) begin
            if (rd_bit) begin
                req.op = OP_READ;
            end else if (!tc_bit) begin
                req.op = OP_WRITE;
            end else begin
                unique case ({rng_hi, rng_lo})
                    2'b01:   req.op = OP_TC_MUX;
                    2'b10:   req.op = OP_TC_ALL;
                    default: req.op = OP_TC_ONE;
                endcase
                // identity: source taken from destination fields
                req.data = {dst_mux, dst_slot};
            end
        end
    end
endmodule

// File: rtl/cml_fill_seq.sv
module cml_fill_seq
    import cml_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cm_op_e           op,
    input  logic [MUX_W-1:0] base_mux,
    output logic             busy,
    output logic             fill_we,
    output cm_addr_t         fill_addr
);
    fill_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.ptr = st_q.ptr + 1'b1;
            if (st_q.ptr == st_q.last) begin
                st_d.busy = 1'b0;
            end
        end else begin
            unique case (op)
                OP_TC_MUX: begin
                    st_d.busy = 1'b1;
                    st_d.ptr  = {base_mux, {SLOT_W{1'b0}}};
                    st_d.last = {base_mux, {SLOT_W{1'b1}}};
                end
                OP_TC_ALL: begin
                    st_d.busy = 1'b1;
                    st_d.ptr  = '0;
                    st_d.last = '1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign fill_we   = st_q.busy;
    assign fill_addr = st_q.ptr;
endmodule

// File: rtl/cml_mem.sv
module cml_mem
    import cml_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  cm_addr_t waddr,
    input  cm_addr_t wdata,
    input  logic     re,
    input  cm_addr_t raddr,
    output logic     rd_valid,
    output cm_addr_t rd_data
);
    cm_addr_t mem_q [DEPTH];
    rd_st_t   rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = re;
        if (re) begin
            rd_d.data = mem_q[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;
endmodule

// File: rtl/conn_mem_loader.sv
module conn_mem_loader
    import cml_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [MUX_W-1:0]  cmd_dst_mux,
    input  logic [SLOT_W-1:0] cmd_dst_slot,
    input  logic [MUX_W-1:0]  cmd_src_mux,
    input  logic [SLOT_W-1:0] cmd_src_slot,
    input  logic              cmd_read,
    input  logic              cmd_tc,
    input  logic              cmd_rng_lo,
    input  logic              cmd_rng_hi,
    output logic              busy,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_data
);
    cm_req_t  req;
    logic     fill_we;
    cm_addr_t fill_addr;
    logic     wr_we;
    cm_addr_t wr_addr;
    cm_addr_t wr_data;

    assign cmd_ready = !busy;

    cml_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .dst_mux   (cmd_dst_mux),
        .dst_slot  (cmd_dst_slot),
        .src_mux   (cmd_src_mux),
        .src_slot  (cmd_src_slot),
        .rd_bit    (cmd_read),
        .tc_bit    (cmd_tc),
        .rng_lo    (cmd_rng_lo),
        .rng_hi    (cmd_rng_hi),
        .req       (req)
    );

    cml_fill_seq u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (req.op),
        .base_mux  (req.addr[ADDR_W-1:SLOT_W]),
        .busy      (busy),
        .fill_we   (fill_we),
        .fill_addr (fill_addr)
    );

    always_comb begin
        wr_we   = fill_we || (req.op == OP_WRITE) || (req.op == OP_TC_ONE);
        wr_addr = fill_we ? fill_addr : req.addr;
        wr_data = fill_we ? fill_addr : req.data;
    end

    cml_mem u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_we),
        .waddr    (wr_addr),
        .wdata    (wr_data),
        .re       (req.op == OP_READ),
        .raddr    (req.addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/cml_chk.sv
module cml_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic cmd_read,
    input logic cmd_tc,
    input logic cmd_rng_lo,
    input logic cmd_rng_hi,
    input logic busy,
    input logic rd_valid
);
    logic [8:0] run_q;
    logic       take;

    assign take = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R9
    rdv_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(take && cmd_read));

    // R3
    rdv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid || $past(take && cmd_read));

    // R6
    fill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !cmd_read && cmd_tc && (cmd_rng_lo != cmd_rng_hi)) |=> busy);

    // R4
    single_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !cmd_read && cmd_tc && (cmd_rng_lo == cmd_rng_hi)) |=> !busy);

    // R7
    fill_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 9'd32 || run_q == 9'd256));

    // R8
    no_read_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_valid);
endmodule

bind conn_mem_loader cml_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_read   (cmd_read),
    .cmd_tc     (cmd_tc),
    .cmd_rng_lo (cmd_rng_lo),
    .cmd_rng_hi (cmd_rng_hi),
    .busy       (busy),
    .rd_valid   (rd_valid)
);

// File: tb/tb_conn_mem_loader.sv
`timescale 1ns/1ps
module tb_conn_mem_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [2:0] cmd_dst_mux = '0;
    logic [4:0] cmd_dst_slot = '0;
    logic [2:0] cmd_src_mux = '0;
    logic [4:0] cmd_src_slot = '0;
    logic       cmd_read = 1'b0;
    logic       cmd_tc = 1'b0;
    logic       cmd_rng_lo = 1'b0;
    logic       cmd_rng_hi = 1'b0;
    logic       busy;
    logic       rd_valid;
    logic [7:0] rd_data;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    int model [256];
    int fill_left = 0;
    int fill_ptr = 0;
    bit exp_rdv = 1'b0;
    int exp_rd = -1;

    always #2.5 clk = ~clk;

    conn_mem_loader dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_dst_mux(cmd_dst_mux), .cmd_dst_slot(cmd_dst_slot),
        .cmd_src_mux(cmd_src_mux), .cmd_src_slot(cmd_src_slot),
        .cmd_read(cmd_read), .cmd_tc(cmd_tc), .cmd_rng_lo(cmd_rng_lo),
        .cmd_rng_hi(cmd_rng_hi), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // behavioural reference model, updated at each active edge
    initial for (int i = 0; i < 256; i++) model[i] = -1;

    always @(posedge clk) begin
        if (!rst_n) begin
            fill_left = 0;
            exp_rdv   = 1'b0;
        end else begin
            exp_rdv = 1'b0;
            if (fill_left > 0) begin
                model[fill_ptr] = fill_ptr;
                fill_ptr++;
                fill_left--;
            end else if (cmd_valid) begin
                int a;
                a = int'(cmd_dst_mux) * 32 + int'(cmd_dst_slot);
                if (cmd_read) begin
                    exp_rdv = 1'b1;
                    exp_rd  = model[a];
                end else if (!cmd_tc) begin
                    model[a] = int'(cmd_src_mux) * 32 + int'(cmd_src_slot);
                end else if (cmd_rng_lo && !cmd_rng_hi) begin
                    fill_left = 32;
                    fill_ptr  = int'(cmd_dst_mux) * 32;
                end else if (cmd_rng_hi && !cmd_rng_lo) begin
                    fill_left = 256;
                    fill_ptr  = 0;
                end else begin
                    model[a] = a;
                end
            end
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 busy", busy, fill_left > 0);
            chk("R8 ready", cmd_ready, fill_left == 0);
            chk("R9 rd_valid", rd_valid, exp_rdv);
            if (exp_rdv) chk({cur_req, " rd_data"}, rd_data, exp_rd);
        end
    end

    task automatic send(int dm, int ds, int sm, int ss, bit rd, bit tc, bit lo, bit hi);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_dst_mux  = dm[2:0];
        cmd_dst_slot = ds[4:0];
        cmd_src_mux  = sm[2:0];
        cmd_src_slot = ss[4:0];
        cmd_read     = rd;
        cmd_tc       = tc;
        cmd_rng_lo   = lo;
        cmd_rng_hi   = hi;
        cmd_valid    = 1'b1;
        @(negedge clk);
        cmd_valid    = 1'b0;
    endtask

    task automatic rd_entry(int dm, int ds);
        send(dm, ds, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 ready", cmd_ready, 1);
        chk("R1 rd_valid", rd_valid, 0);

        // R7: fill every entry, source fields hold junk
        cur_req = "R7";
        send(6, 17, 5, 3, 1'b0, 1'b1, 1'b0, 1'b1);
        wait_idle();
        rd_entry(0, 0);
        rd_entry(1, 5);
        rd_entry(7, 31);
        rd_entry(4, 16);

        // R2: normal writes
        cur_req = "R2";
        send(3, 7, 5, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        send(0, 31, 7, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        send(7, 0, 0, 31, 1'b0, 1'b0, 1'b0, 1'b0);
        rd_entry(3, 7);
        rd_entry(0, 31);
        rd_entry(7, 0);

        // R3: read with the transparent bit set changes nothing
        cur_req = "R3";
        send(3, 7, 1, 1, 1'b1, 1'b1, 1'b1, 1'b0);
        send(3, 7, 2, 2, 1'b1, 1'b1, 1'b0, 1'b0);
        rd_entry(3, 7);

        // R4: single transparent connection, source ignored
        cur_req = "R4";
        send(2, 9, 6, 6, 1'b0, 1'b0, 1'b0, 1'b0);
        send(2, 9, 1, 3, 1'b0, 1'b1, 1'b0, 1'b0);
        rd_entry(2, 9);

        // R5: both range bits set acts as single
        cur_req = "R5";
        send(5, 12, 0, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        send(5, 13, 0, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        send(5, 12, 3, 3, 1'b0, 1'b1, 1'b1, 1'b1);
        rd_entry(5, 12);
        rd_entry(5, 13);

        // R6: one multiplex filled, neighbours untouched
        cur_req = "R6";
        send(4, 10, 1, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        send(4, 31, 2, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        send(5, 0, 6, 6, 1'b0, 1'b0, 1'b0, 1'b0);
        send(3, 31, 6, 7, 1'b0, 1'b0, 1'b0, 1'b0);
        send(4, 3, 7, 7, 1'b0, 1'b1, 1'b1, 1'b0);
        wait_idle();
        for (int s = 0; s < 32; s++) rd_entry(4, s);
        rd_entry(5, 0);
        rd_entry(3, 31);

        // R8: command held during a fill is refused
        cur_req = "R8";
        send(1, 1, 2, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        send(0, 0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b1);
        cmd_dst_mux  = 3'd1;
        cmd_dst_slot = 5'd1;
        cmd_src_mux  = 3'd6;
        cmd_src_slot = 5'd20;
        cmd_read     = 1'b0;
        cmd_tc       = 1'b0;
        cmd_rng_lo   = 1'b0;
        cmd_rng_hi   = 1'b0;
        cmd_valid    = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R8 refused while busy", cmd_ready, 0);
        end
        cmd_valid = 1'b0;
        wait_idle();
        rd_entry(1, 1);
        rd_entry(0, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule